// File: doc/BRIEF.md
# Serial Flash Command Gate with Write Protection

This block is the command front end of a serial NOR flash slave. It takes the SPI mode 0 pins (active-low select, serial clock, serial data in), oversamples them in the local clock domain and assembles each framed instruction. It keeps the volatile protection state: the write-enable latch, a three-bit protected-range field, the status-lock bit and a deep power-down flag. When a select window closes, it decides whether the instruction may take effect.

An accepted page program, sector erase or bulk erase leaves the block as a single-cycle execute strobe, carrying the opcode and the 24-bit address, to a memory-array model. An accepted status write updates the protection state in place. The status byte is shifted out on `miso_o` during a status read. The array, its timing and the busy timer sit outside the block. The busy timer is represented by `busy_i`.

Top module: `flash_wp_ctrl`

## Requirements
- R1: Bits are taken on rising serial-clock edges while `cs_ni` is low, MSB first. The first byte is the opcode, and for program and erase the next three bytes are the address. Page program is 0x02, sector erase 0xD8, bulk erase 0xC7 and status write 0x01.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. After opcode 0x05, the status byte is driven on `miso_o` MSB first, repeating every 8 clocks. Status bit 0 is busy, bit 1 the latch, bits 4:2 the range field, bit 7 the lock bit, and bits 6:5 read 0.
- R3: A modifying instruction is accepted only when its clock count is a multiple of 8 and at least its minimum length. The minimums are 40 for program, 32 for sector erase, 8 for bulk erase and 16 for status write. Any other count drops it with no effect.
- R4: A modifying instruction issued while the latch is clear has no effect.
- R5: An accepted program or erase raises `exec_o` for exactly one cycle, with `exec_op_o` and `exec_addr_o` holding the opcode and the address. Acceptance of any modifying instruction clears the latch.
- R6: For a range field value b between 1 and 6, addresses at or above 2 MB − (2 MB >> (7−b)) are protected, and b = 7 protects the whole array. A program or sector erase to a protected address is rejected, and the latch stays set.
- R7: Bulk erase is rejected, with the latch kept, whenever the range field is nonzero.
- R8: An accepted status write loads the range field from data bits 4:2 and the lock bit from data bit 7. The other data bits are ignored.
- R9: While the lock bit is 1 and `wp_ni` is low, a status write is rejected, and the latch stays set.
- R10: Opcode 0xB9 enters power-down and opcode 0xAB leaves it. While powered down, every other opcode is ignored and `miso_o` stays 0.
- R11: While `busy_i` is high at the close of a frame, the frame has no effect. A status read still works during this time.
- R12: After reset, the status reads 0x00, no strobe is raised, and the block is not powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock, mode 0 |
| mosi_i | input | 1 | SPI serial data in |
| wp_ni | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Array operation in progress |
| miso_o | output | 1 | SPI serial data out (status read) |
| exec_o | output | 1 | One-cycle execute strobe |
| exec_op_o | output | 8 | Opcode of the executed instruction |
| exec_addr_o | output | 24 | Address of the executed instruction |

## Verification
The properties assume that `wp_ni` and `busy_i` hold steady across the clock edge on which a frame closes. They also assume that every SPI clock phase spans several local clock cycles, so that the synchronizer sees each edge. The stimulus meets this by changing inputs only on falling local-clock edges and using four-cycle SPI half periods. It also changes `wp_ni` and `busy_i` only while select is high, and ends every frame with the serial clock low.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_DPD  = 8'hB9;
  localparam logic [7:0] OP_WAKE = 8'hAB;
  // status bits kept by a status write: lock bit and range field
  localparam logic [7:0] SR_WR_MASK = 8'h9C;
endpackage

// File: rtl/flash_wp_sync.sv
module flash_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic sel_o,
  output logic sclk_rise_o,
  output logic frame_start_o,
  output logic frame_end_o,
  output logic mosi_o
);
  localparam logic [2:0] RST_VAL = 3'b100;  // {cs, sclk, mosi}

  logic [STAGES-1:0][2:0] pipe_q;
  logic prev_cs_q, prev_sclk_q;
  logic [2:0] last;

  assign last = pipe_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q      <= {STAGES{RST_VAL}};
      prev_cs_q   <= 1'b1;
      prev_sclk_q <= 1'b0;
    end else begin
      pipe_q[0] <= {cs_ni, sclk_i, mosi_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      prev_cs_q   <= last[2];
      prev_sclk_q <= last[1];
    end
  end

  assign sel_o         = ~last[2];
  assign sclk_rise_o   = last[1] & ~prev_sclk_q & ~last[2];
  assign frame_start_o = ~last[2] & prev_cs_q;
  assign frame_end_o   = last[2] & ~prev_cs_q;
  assign mosi_o        = last[0];
endmodule

// File: rtl/flash_wp_frame.sv
module flash_wp_frame #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             bit_en_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       op_o,
  output logic [7:0]       data_o,
  output logic [23:0]      addr_o
);
  localparam logic [CNT_W-1:0] LAST_OP   = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(15);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(31);

  logic [22:0] shift_q;
  logic [23:0] shift_nxt;

  assign shift_nxt = {shift_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_o   <= '0;
      op_o    <= '0;
      data_o  <= '0;
      addr_o  <= '0;
    end else if (frame_start_i) begin
      cnt_o <= '0;
      op_o  <= '0;  // 0x00 decodes to nothing
    end else if (bit_en_i) begin
      shift_q <= shift_nxt[22:0];
      if (!(&cnt_o)) cnt_o <= cnt_o + 1'b1;
      if (cnt_o == LAST_OP)   op_o   <= shift_nxt[7:0];
      if (cnt_o == LAST_DATA) data_o <= shift_nxt[7:0];
      if (cnt_o == LAST_ADDR) addr_o <= shift_nxt;
    end
  end
endmodule

// File: rtl/flash_wp_range.sv
module flash_wp_range (
  input  logic [2:0] bp_i,
  input  logic [5:0] top_i,   // six MSBs of the array address
  output logic       prot_o
);
  logic [5:0] mask;

  // range field b keeps the top (7-b) address MSBs all ones
  assign mask   = 6'h3F << (bp_i - 3'd1);
  assign prot_o = (bp_i == 3'b111) || ((bp_i != 3'b000) && ((top_i & mask) == mask));
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_ni,
  input  logic        sclk_i,
  input  logic        mosi_i,
  input  logic        wp_ni,
  input  logic        busy_i,
  output logic        miso_o,
  output logic        exec_o,
  output logic [7:0]  exec_op_o,
  output logic [23:0] exec_addr_o
);
  localparam logic [CNT_W-1:0] MIN_PP   = CNT_W'(40);
  localparam logic [CNT_W-1:0] MIN_SE   = CNT_W'(32);
  localparam logic [CNT_W-1:0] MIN_BE   = CNT_W'(8);
  localparam logic [CNT_W-1:0] MIN_WRSR = CNT_W'(16);

  logic sel, sclk_rise, frame_start, frame_end, mosi_s;
  logic [CNT_W-1:0] cnt;
  logic [7:0] op, data;
  logic [23:0] addr;
  logic prot;

  logic       wel_q, wel_d;
  logic       dpd_q, dpd_d;
  logic [7:0] lock_q, lock_d;   // holds lock bit and range field only
  logic [2:0] bp_q;
  logic       srwd_q;
  logic [7:0] status;
  logic       fire, whole, hw_lock;

  flash_wp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .mosi_i,
    .sel_o(sel), .sclk_rise_o(sclk_rise), .frame_start_o(frame_start),
    .frame_end_o(frame_end), .mosi_o(mosi_s)
  );

  flash_wp_frame #(.CNT_W(CNT_W)) i_frame (
    .clk_i, .rst_ni, .frame_start_i(frame_start), .bit_en_i(sclk_rise),
    .bit_i(mosi_s), .cnt_o(cnt), .op_o(op), .data_o(data), .addr_o(addr)
  );

  flash_wp_range i_range (
    .bp_i(bp_q), .top_i(addr[ADDR_W-1 -: 6]), .prot_o(prot)
  );

  assign bp_q    = lock_q[4:2];
  assign srwd_q  = lock_q[7];
  assign status  = lock_q | {6'b0, wel_q, busy_i};
  assign whole   = (cnt[2:0] == 3'b000);
  assign hw_lock = srwd_q & ~wp_ni;

  always_comb begin
    wel_d  = wel_q;
    dpd_d  = dpd_q;
    lock_d = lock_q;
    fire   = 1'b0;
    if (frame_end && !busy_i) begin
      if (dpd_q) begin
        if (op == OP_WAKE) dpd_d = 1'b0;
      end else begin
        case (op)
          OP_WREN: wel_d = 1'b1;
          OP_WRDI: wel_d = 1'b0;
          OP_DPD:  dpd_d = 1'b1;
          OP_WRSR: if (whole && cnt >= MIN_WRSR && wel_q && !hw_lock) begin
            lock_d = data & SR_WR_MASK;
            wel_d  = 1'b0;
          end
          OP_PP: if (whole && cnt >= MIN_PP && wel_q && !prot) begin
            fire  = 1'b1;
            wel_d = 1'b0;
          end
          OP_SE: if (whole && cnt >= MIN_SE && wel_q && !prot) begin
            fire  = 1'b1;
            wel_d = 1'b0;
          end
          OP_BE: if (whole && cnt >= MIN_BE && wel_q && bp_q == 3'b000) begin
            fire  = 1'b1;
            wel_d = 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q       <= 1'b0;
      dpd_q       <= 1'b0;
      lock_q      <= '0;
      exec_o      <= 1'b0;
      exec_op_o   <= '0;
      exec_addr_o <= '0;
    end else begin
      wel_q  <= wel_d;
      dpd_q  <= dpd_d;
      lock_q <= lock_d;
      exec_o <= fire;
      if (fire) begin
        exec_op_o   <= op;
        exec_addr_o <= (op == OP_BE) ? 24'h0 : addr;
      end
    end
  end

  // status shifts out MSB first once the read opcode is in
  always_comb begin
    miso_o = 1'b0;
    if (sel && !dpd_q && op == OP_RDSR && cnt >= CNT_W'(8))
      miso_o = status[~cnt[2:0]];
  end
endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk
  import flash_wp_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_ni,
  input logic       busy_i,
  input logic       exec_i,
  input logic [7:0] exec_op_i,
  input logic       wel_i,
  input logic       dpd_i,
  input logic       srwd_i,
  input logic [2:0] bp_i
);
  p_exec_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> !exec_i);

  p_exec_clears_wel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |-> !wel_i);

  p_exec_needs_wel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |-> $past(wel_i));

  p_bulk_unprotected_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && exec_op_i == OP_BE) |-> (bp_i == 3'b000));

  p_hw_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srwd_i && !wp_ni) |=> (srwd_i && bp_i == $past(bp_i)));

  p_busy_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!exec_i && wel_i == $past(wel_i) && dpd_i == $past(dpd_i)));

  p_dpd_no_exec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpd_i |=> !exec_i);
endmodule

bind flash_wp_ctrl flash_wp_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wp_ni(wp_ni), .busy_i(busy_i),
  .exec_i(exec_o), .exec_op_i(exec_op_o), .wel_i(wel_q), .dpd_i(dpd_q),
  .srwd_i(srwd_q), .bp_i(bp_q)
);

// File: tb/test_flash_wp_ctrl.sv
module test_flash_wp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1, busy = 1'b0;
  logic miso, exec;
  logic [7:0] exec_op;
  logic [23:0] exec_addr;

  int checks = 0, fails = 0, exec_cnt = 0;
  logic [7:0] last_op = '0;
  logic [23:0] last_addr = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_wp_ctrl i_flash_wp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .wp_ni(wp_n), .busy_i(busy), .miso_o(miso), .exec_o(exec),
    .exec_op_o(exec_op), .exec_addr_o(exec_addr)
  );

  always @(negedge clk) if (exec) begin
    exec_cnt++;
    last_op   = exec_op;
    last_addr = exec_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [63:0] bits, input int n);
    cs_n = 1'b0;
    ticks(4);
    for (int i = 0; i < n; i++) begin
      mosi = bits[n-1-i];
      ticks(4);
      sclk = 1'b1;
      ticks(4);
      sclk = 1'b0;
    end
    ticks(4);
    cs_n = 1'b1;
    ticks(10);
  endtask

  task automatic op8(input logic [7:0] op);
    frame({56'h0, op}, 8);
  endtask

  task automatic read_sr(output logic [7:0] sr);
    cs_n = 1'b0;
    ticks(4);
    for (int i = 0; i < 8; i++) begin
      mosi = 8'h05 >> (7 - i);
      ticks(4);
      sclk = 1'b1;
      ticks(4);
      sclk = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      ticks(4);
      sr[7-i] = miso;
      sclk = 1'b1;
      ticks(4);
      sclk = 1'b0;
    end
    ticks(4);
    cs_n = 1'b1;
    ticks(10);
  endtask

  task automatic wrsr(input logic [7:0] d);
    op8(8'h06);
    frame({48'h0, 8'h01, d}, 16);
  endtask

  task automatic t_reset;
    logic [7:0] sr;
    chk("R12 miso idle", miso, 0);
    read_sr(sr);
    chk("R12 status after reset", sr, 8'h00);
    chk("R12 no strobe", exec_cnt, 0);
  endtask

  task automatic t_latch;
    logic [7:0] sr;
    op8(8'h06);
    read_sr(sr);
    chk("R2 write enable sets bit1", sr, 8'h02);
    op8(8'h04);
    read_sr(sr);
    chk("R2 write disable clears", sr, 8'h00);
  endtask

  task automatic t_program;
    logic [7:0] sr;
    int n0 = exec_cnt;
    op8(8'h06);
    frame({24'h0, 8'h02, 24'h012345, 8'hA5}, 40);
    chk("R5 program strobe count", exec_cnt - n0, 1);
    chk("R1 program opcode", last_op, 8'h02);
    chk("R1 program address MSB first", last_addr, 24'h012345);
    read_sr(sr);
    chk("R5 latch cleared after program", sr, 8'h00);
    n0 = exec_cnt;
    frame({24'h0, 8'h02, 24'h000100, 8'h11}, 40);
    chk("R4 program without latch ignored", exec_cnt - n0, 0);
  endtask

  task automatic t_length;
    logic [7:0] sr;
    int n0 = exec_cnt;
    op8(8'h06);
    frame({23'h0, 8'h02, 24'h000200, 8'h11, 1'b1}, 41);
    frame({31'h0, 8'hD8, 24'h000200, 1'b0}, 33);
    frame({32'h0, 8'h02, 24'h000200}, 32);
    chk("R3 bad lengths dropped", exec_cnt - n0, 0);
    read_sr(sr);
    chk("R3 latch kept after dropped frames", sr, 8'h02);
    frame({32'h0, 8'hD8, 24'h1F0000}, 32);
    chk("R5 sector erase strobe", exec_cnt - n0, 1);
    chk("R5 sector erase opcode", last_op, 8'hD8);
    chk("R5 sector erase address", last_addr, 24'h1F0000);
  endtask

  task automatic t_ranges;
    logic [7:0] sr;
    int n0;
    wrsr(8'hFF);
    read_sr(sr);
    chk("R8 status write keeps lock and range only", sr, 8'h9C);
    wrsr(8'h04);  // range 1: top 1/64
    read_sr(sr);
    chk("R8 range field 001", sr, 8'h04);
    n0 = exec_cnt;
    op8(8'h06);
    frame({24'h0, 8'h02, 24'h1F8000, 8'h00}, 40);
    chk("R6 program at protected edge rejected", exec_cnt - n0, 0);
    read_sr(sr);
    chk("R6 latch kept after rejection", sr, 8'h06);
    frame({24'h0, 8'h02, 24'h1F7FFF, 8'h00}, 40);
    chk("R6 program just below range accepted", exec_cnt - n0, 1);
    op8(8'h06);
    op8(8'hC7);
    chk("R7 bulk erase rejected with range set", exec_cnt - n0, 1);
    read_sr(sr);
    chk("R7 latch kept", sr, 8'h06);
    wrsr(8'h18);  // range 6: upper half
    op8(8'h06);
    frame({32'h0, 8'hD8, 24'h100000}, 32);
    chk("R6 upper half protected", exec_cnt - n0, 1);
    frame({32'h0, 8'hD8, 24'h0FFFFF}, 32);
    chk("R6 lower half erasable", exec_cnt - n0, 2);
    wrsr(8'h1C);  // all
    op8(8'h06);
    frame({32'h0, 8'hD8, 24'h000000}, 32);
    chk("R6 range 111 protects all", exec_cnt - n0, 2);
    wrsr(8'h00);
    op8(8'h06);
    op8(8'hC7);
    chk("R7 bulk erase with range 000", exec_cnt - n0, 3);
    chk("R7 bulk erase opcode", last_op, 8'hC7);
  endtask

  task automatic t_hw_lock;
    logic [7:0] sr;
    wrsr(8'h80);
    read_sr(sr);
    chk("R8 lock bit set with pin high", sr, 8'h80);
    wp_n = 1'b0;
    wrsr(8'h1C);
    read_sr(sr);
    chk("R9 status write blocked by pin", sr, 8'h82);
    wp_n = 1'b1;
    frame({48'h0, 8'h01, 8'h00}, 16);
    read_sr(sr);
    chk("R9 unlocked once pin high", sr, 8'h00);
  endtask

  task automatic t_power_down;
    logic [7:0] sr;
    int n0;
    op8(8'hB9);
    op8(8'h06);
    read_sr(sr);
    chk("R10 status read silent in power-down", sr, 8'h00);
    op8(8'hAB);
    read_sr(sr);
    chk("R10 write enable ignored in power-down", sr, 8'h00);
    op8(8'h06);
    op8(8'hB9);
    n0 = exec_cnt;
    frame({24'h0, 8'h02, 24'h000040, 8'h00}, 40);
    op8(8'h04);
    chk("R10 program ignored in power-down", exec_cnt - n0, 0);
    op8(8'hAB);
    read_sr(sr);
    chk("R10 latch untouched across power-down", sr, 8'h02);
  endtask

  task automatic t_busy;
    logic [7:0] sr;
    int n0 = exec_cnt;
    busy = 1'b1;
    read_sr(sr);
    chk("R11 busy shown while latch set", sr, 8'h03);
    frame({24'h0, 8'h02, 24'h000080, 8'h00}, 40);
    op8(8'h04);
    chk("R11 program ignored while busy", exec_cnt - n0, 0);
    busy = 1'b0;
    read_sr(sr);
    chk("R11 write disable ignored while busy", sr, 8'h02);
    op8(8'h04);
    busy = 1'b1;
    op8(8'h06);
    busy = 1'b0;
    read_sr(sr);
    chk("R11 write enable ignored while busy", sr, 8'h00);
  endtask

  initial begin
    ticks(5);
    rst_n = 1'b1;
    ticks(5);
    t_reset();
    t_latch();
    t_program();
    t_length();
    t_ranges();
    t_hw_lock();
    t_power_down();
    t_busy();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule